// File: doc/BRIEF.md
# Modulo Address Step Unit

This block computes the pointer value that follows a post-increment data access. It takes the current address, the access stride (1, 2 or 4 bytes), a circular-buffer enable, and the first and last addresses of the circular region. In linear mode the pointer moves forward by the stride. In circular mode it moves back to the first address of the region once it reaches the last slot of the region.

When circular mode is on, the last address is aligned down to the stride before it is compared with the current pointer. For this reason a 2- or 4-byte access still wraps when the configured last address is not a multiple of the stride. A stride code that is not a power of two is flagged on an error output, and the block uses a stride of 2 for it.

The next-address path is purely combinational. An optional pointer register, chosen by a parameter, captures the next address on a single-cycle update strobe and holds its value otherwise.

Top module: `modaddr_step`

## Requirements
- R1: With `wrap_en` low, `next_addr` equals `cur_addr` plus the effective stride.
- R2: With `wrap_en` high and `cur_addr` equal to the aligned last address, `next_addr` equals `wrap_start`.
- R3: The aligned last address is `wrap_end` with every bit below the stride cleared, that is `wrap_end & ~(stride-1)`. Example: with last address 0x0203, stride 4 wraps at 0x0200 and stride 2 wraps at 0x0202.
- R4: With `wrap_en` high and no match against the aligned last address, `next_addr` equals `cur_addr` plus the stride.
- R5: Address arithmetic is modulo 2^ADDR_W. Example: 0xFFFF plus 2 gives 0x0001.
- R6: `inc_size` is a binary stride value. The codes 1, 2 and 4 give `inc_err` = 0. Any code that is not one-hot (0, 3, 5, 6, 7) gives `inc_err` = 1 and is treated as stride 2, for both the addition and the alignment.
- R7: When PTR_REG = 1, `ptr_q` takes the value of `next_addr` on the clock edge where `ptr_upd` is high, and keeps its value on every other edge.
- R8: While `rst_n` is low, `ptr_q` is held at the parameter RST_VAL (default 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the pointer register |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_addr | input | ADDR_W | Current pointer value |
| inc_size | input | MAX_SHIFT+1 | Stride in bytes, binary (1, 2 or 4) |
| wrap_en | input | 1 | Circular-buffer mode enable |
| wrap_start | input | ADDR_W | First address of the circular region |
| wrap_end | input | ADDR_W | Last address of the circular region |
| ptr_upd | input | 1 | Single-cycle strobe that loads the pointer |
| next_addr | output | ADDR_W | Computed next address |
| inc_err | output | 1 | Stride code is not a power of two |
| ptr_q | output | ADDR_W | Registered pointer (equals next_addr when PTR_REG = 0) |

## Verification
The bench builds the block with ADDR_W = 16, MAX_SHIFT = 2 and PTR_REG = 1. The 3-bit stride field can then carry every illegal code as well as the three legal ones, and the update and hold behaviour of the pointer register is exercised. The 16-bit width puts the 0xFFFF rollover within reach of directed cases. Random cases force the current address onto the aligned last address often enough that the circular-mode wrap, including end addresses that are not aligned to the stride, shows up under every stride code.

// File: rtl/mai_pkg.sv
package mai_pkg;

   // Number of address bits cleared for a stride of 2**shift.
   function automatic int unsigned stride_bits(input int unsigned shift);
      return shift;
   endfunction

   // Fallback stride used when the stride code is illegal.
   localparam int unsigned FALLBACK_STRIDE = 2;

endpackage

// File: rtl/mai_inc_decode.sv
module mai_inc_decode #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned MAX_SHIFT = 2
) (
   input  logic [MAX_SHIFT:0]  inc_in,
   output logic [MAX_SHIFT:0]  inc_eff,
   output logic [ADDR_W-1:0]   align_mask,
   output logic                bad_code
);
   import mai_pkg::*;

   localparam int unsigned INC_W = MAX_SHIFT + 1;

   logic              legal;
   logic [INC_W-1:0]  low_bits;

   always_comb begin
      legal = 1'b0;
      for (int k = 0; k < INC_W; k++) begin
         if (inc_in == INC_W'(1 << k)) legal = 1'b1;
      end
   end

   assign bad_code   = ~legal;
   assign inc_eff    = legal ? inc_in : INC_W'(FALLBACK_STRIDE);
   assign low_bits   = inc_eff - INC_W'(1);
   assign align_mask = ~ADDR_W'(low_bits);

   // R6: the effective stride is always a single set bit
   always_comb begin
      if (!$isunknown(inc_in)) begin
         a_eff_onehot_r6: assert ($onehot(inc_eff))
            else $error("effective stride not one-hot");
      end
   end

endmodule

// File: rtl/mai_wrap_cmp.sv
module mai_wrap_cmp #(
   parameter int unsigned ADDR_W = 16
) (
   input  logic              mode_on,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] last_addr,
   input  logic [ADDR_W-1:0] mask,
   output logic              at_end
);
   logic [ADDR_W-1:0] last_aligned;

   assign last_aligned = last_addr & mask;
   assign at_end       = mode_on && (addr == last_aligned);

endmodule

// File: rtl/mai_ptr_reg.sv
module mai_ptr_reg #(
   parameter int unsigned ADDR_W  = 16,
   parameter bit          PTR_REG = 1'b1,
   parameter logic [ADDR_W-1:0] RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] d,
   output logic [ADDR_W-1:0] q
);
   generate
      if (PTR_REG) begin : g_reg
         logic [ADDR_W-1:0] q_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    q_r <= RST_VAL;
            else if (load) q_r <= d;
         end
         assign q = q_r;

         p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
            load |=> (q == $past(d)))
            else $error("pointer missed load");
         p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !load |=> $stable(q))
            else $error("pointer moved without strobe");
      end else begin : g_thru
         assign q = d;
      end
   endgenerate

endmodule

// File: rtl/modaddr_step.sv
module modaddr_step #(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned MAX_SHIFT = 2,
   parameter bit          PTR_REG   = 1'b1,
   parameter logic [ADDR_W-1:0] RST_VAL = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [ADDR_W-1:0]    cur_addr,
   input  logic [MAX_SHIFT:0]   inc_size,
   input  logic                 wrap_en,
   input  logic [ADDR_W-1:0]    wrap_start,
   input  logic [ADDR_W-1:0]    wrap_end,
   input  logic                 ptr_upd,
   output logic [ADDR_W-1:0]    next_addr,
   output logic                 inc_err,
   output logic [ADDR_W-1:0]    ptr_q
);
   localparam int unsigned INC_W = MAX_SHIFT + 1;

   generate
      if (MAX_SHIFT < 1) begin : g_bad_shift
         $error("MAX_SHIFT must be at least 1 so the fallback stride fits");
      end
      if (ADDR_W <= INC_W) begin : g_bad_width
         $error("ADDR_W must exceed the stride field width");
      end
   endgenerate

   logic [INC_W-1:0]  stride;
   logic [ADDR_W-1:0] mask;
   logic              hit;
   logic [ADDR_W-1:0] sum;

   mai_inc_decode #(.ADDR_W(ADDR_W), .MAX_SHIFT(MAX_SHIFT)) u_dec (
      .inc_in     (inc_size),
      .inc_eff    (stride),
      .align_mask (mask),
      .bad_code   (inc_err)
   );

   mai_wrap_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .mode_on   (wrap_en),
      .addr      (cur_addr),
      .last_addr (wrap_end),
      .mask      (mask),
      .at_end    (hit)
   );

   assign sum       = cur_addr + ADDR_W'(stride);
   assign next_addr = hit ? wrap_start : sum;

   mai_ptr_reg #(.ADDR_W(ADDR_W), .PTR_REG(PTR_REG), .RST_VAL(RST_VAL)) u_ptr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ptr_upd),
      .d     (next_addr),
      .q     (ptr_q)
   );

   p_linear_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap_en |-> (next_addr == cur_addr + ADDR_W'(stride)))
      else $error("linear step wrong");

   p_wrap_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap_en && hit) |-> (next_addr == wrap_start))
      else $error("wrap did not return to start");

   p_err_fallback_r6: assert property (@(posedge clk) disable iff (!rst_n)
      inc_err |-> (stride == INC_W'(2)))
      else $error("illegal stride not replaced by 2");

   p_no_hit_linear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (next_addr == cur_addr + ADDR_W'(stride)))
      else $error("non-wrapping step wrong");

endmodule

// File: tb/tb_modaddr_step.sv
module tb_modaddr_step;
   localparam int unsigned AW = 16;
   localparam int unsigned MS = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] cur_addr = '0;
   logic [MS:0]   inc_size = 3'd1;
   logic          wrap_en = 1'b0;
   logic [AW-1:0] wrap_start = '0;
   logic [AW-1:0] wrap_end = '0;
   logic          ptr_upd = 1'b0;
   logic [AW-1:0] next_addr;
   logic          inc_err;
   logic [AW-1:0] ptr_q;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   modaddr_step #(.ADDR_W(AW), .MAX_SHIFT(MS), .PTR_REG(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .cur_addr(cur_addr), .inc_size(inc_size),
      .wrap_en(wrap_en), .wrap_start(wrap_start), .wrap_end(wrap_end),
      .ptr_upd(ptr_upd), .next_addr(next_addr), .inc_err(inc_err), .ptr_q(ptr_q)
   );

   function automatic bit ref_err(input logic [MS:0] c);
      return !(c == 3'd1 || c == 3'd2 || c == 3'd4);
   endfunction

   function automatic logic [AW-1:0] ref_next(input logic [AW-1:0] a, input logic [MS:0] c,
                                              input logic en, input logic [AW-1:0] s,
                                              input logic [AW-1:0] e);
      int unsigned st;
      logic [AW-1:0] ae;
      st = ref_err(c) ? 2 : int'(c);
      ae = e & ~AW'(st - 1);
      if (en && a == ae) return s;
      return AW'(int'(a) + st);
   endfunction

   task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply(input string req, input logic [AW-1:0] a, input logic [MS:0] c,
                        input logic en, input logic [AW-1:0] s, input logic [AW-1:0] e);
      @(negedge clk);
      cur_addr = a; inc_size = c; wrap_en = en; wrap_start = s; wrap_end = e;
      #1;
      chk(req, next_addr, ref_next(a, c, en, s, e));
      chk({req, " err"}, AW'(inc_err), AW'(ref_err(c)));
   endtask

   initial begin
      #400000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] held;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk("R8 reset value", ptr_q, 16'h0000);
      rst_n = 1'b1;

      apply("R1 linear +4", 16'h1000, 3'd4, 1'b0, 16'h0000, 16'h1000);
      apply("R1 linear +1", 16'h2345, 3'd1, 1'b0, 16'h0000, 16'h0000);
      apply("R2 wrap stride1", 16'h02FF, 3'd1, 1'b1, 16'h0200, 16'h02FF);
      apply("R3 unaligned end stride4", 16'h0200, 3'd4, 1'b1, 16'h0100, 16'h0203);
      apply("R3 unaligned end stride2", 16'h0202, 3'd2, 1'b1, 16'h0100, 16'h0203);
      apply("R3 exact end stride1", 16'h0203, 3'd1, 1'b1, 16'h0100, 16'h0203);
      apply("R4 no match in wrap mode", 16'h0150, 3'd4, 1'b1, 16'h0100, 16'h0203);
      apply("R4 past aligned end", 16'h0201, 3'd4, 1'b1, 16'h0100, 16'h0203);
      apply("R5 rollover", 16'hFFFF, 3'd2, 1'b0, 16'h0000, 16'h0000);
      apply("R6 code 3", 16'h0010, 3'd3, 1'b0, 16'h0000, 16'h0000);
      apply("R6 code 0", 16'h0010, 3'd0, 1'b0, 16'h0000, 16'h0000);
      apply("R6 code 7 aligns as 2", 16'h0202, 3'd7, 1'b1, 16'h0100, 16'h0203);

      // R7 load and hold
      apply("R7 setup", 16'h0ABC, 3'd4, 1'b0, 16'h0000, 16'h0000);
      ptr_upd = 1'b1;
      @(negedge clk);
      ptr_upd = 1'b0;
      chk("R7 load", ptr_q, 16'h0AC0);
      held = ptr_q;
      cur_addr = 16'h7777;
      repeat (2) @(negedge clk);
      chk("R7 hold", ptr_q, held);

      for (int i = 0; i < 400; i++) begin
         logic [AW-1:0] a, s, e;
         logic [MS:0] c;
         logic en;
         s  = AW'($urandom);
         e  = AW'($urandom);
         c  = (MS+1)'($urandom % 8);
         en = 1'($urandom);
         a  = ($urandom % 3 == 0) ? (e & ~AW'((ref_err(c) ? 2 : int'(c)) - 1)) : AW'($urandom);
         apply(en ? "R2/R3/R4 random wrap mode" : "R1/R5 random linear", a, c, en, s, e);
         if ($urandom % 4 == 0) begin
            ptr_upd = 1'b1;
            @(negedge clk);
            ptr_upd = 1'b0;
            chk("R7 random load", ptr_q, ref_next(a, c, en, s, e));
         end
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule